// File: doc/BRIEF.md
# Bus Ownership Handshake Controller

This block manages bus ownership for one master on an external bus that uses three-wire arbitration. The local transfer sequencer raises a request when it has an access waiting. The block tells the external arbiter about that need and watches the grant input. It then decides when the local master may start an access, when it must keep driving the bus, and when it must let go. It drives a bus-request status line, a bus-driven line that marks an access in flight, a single enable that turns the external address, data and control drivers on or off, and a one-cycle start pulse to the sequencer.

Internally a controller walks four ownership states: reset, inactive (another master owns the bus), parked (granted but idle, bus driven with the bus-driven line low) and owner (an access in flight). Once an access has started, the block keeps the bus until the sequencer reports completion, even if the grant is withdrawn. The request line reports only that the bus is needed. It promises no bus cycle and is not an encoding of the ownership state. All inputs are sampled on the rising clock edge and every output is registered, so each decision appears one cycle after the edge that sampled its inputs.

Top module: `mst_bus_own`

## Requirements
- R1: While reset is held, and in the first cycle after the first rising edge with reset released, busReqOut, busDrivenOut, busOe and xferStart are all 0.
- R2: When the bus is not owned (busOe low, reset state left), an edge that samples xferReq=1 and grantIn=0 makes busReqOut 1 in the next cycle. With xferReq=0 it makes busReqOut 0.
- R3: An edge that samples grantIn=1 and xferReq=1 while no access is in flight makes busDrivenOut=1, busOe=1, busReqOut=0 and xferStart=1 in the next cycle. xferStart lasts exactly one cycle.
- R4: An edge that samples grantIn=1 and xferReq=0 while no access is in flight makes busOe=1 with busDrivenOut=0 and busReqOut=0 (parked).
- R5: While parked, an edge that samples xferReq=1 with grantIn still 1 moves to the owner state: busDrivenOut=1 and xferStart=1 in the next cycle.
- R6: While an access is in flight, busDrivenOut and busOe stay 1 on every edge that samples xferDone=0, whatever grantIn is.
- R7: An edge that samples xferDone=1 with grantIn=0 during an access negates busDrivenOut and busOe together in the next cycle. busReqOut then equals the sampled xferReq.
- R8: An edge that samples xferDone=1 with grantIn=1 starts a new access at once (xferStart=1, busDrivenOut stays 1) if xferReq=1. Otherwise it parks (busOe=1, busDrivenOut=0).
- R9: When no access is in flight, an edge that samples grantIn=0 makes busOe 0 in the next cycle.
- R10: xferReq sampled during an access in flight (xferDone=0) has no effect: no xferStart and no busReqOut in the next cycle.
- R11: busDrivenOut=1 always comes with busOe=1, and busReqOut=1 never comes with busOe=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| xferReq | input | 1 | Internal access pending; cleared by the sequencer once it sees xferStart |
| xferDone | input | 1 | The access in flight completes on this edge |
| grantIn | input | 1 | Bus grant from the external arbiter, active high |
| busReqOut | output | 1 | Bus-request status to the arbiter, active high |
| busDrivenOut | output | 1 | Access in flight, local master is explicit owner |
| busOe | output | 1 | Output enable for the external address, data and control drivers |
| xferStart | output | 1 | One-cycle pulse telling the sequencer to begin an access |

## Verification
The properties assume that xferDone is only raised while busDrivenOut is high. They also assume that the sequencer drops xferReq in the cycle after it sees xferStart, so one request is never counted as two accesses. The random stimulus keeps both rules: completion pulses are drawn only in cycles where the bench model expects an access in flight, and the request is forced low whenever the model expects a start pulse. The grant is otherwise free to rise and fall in any cycle, including in the middle of an access.

// File: rtl/mst_bus_own_pkg.sv
package mst_bus_own_pkg;

  typedef enum logic [1:0] {
    ST_RESET    = 2'd0,
    ST_INACTIVE = 2'd1,
    ST_PARKED   = 2'd2,
    ST_OWNER    = 2'd3
  } arbState_t;

  typedef struct packed {
    logic drvBus;
    logic drvBd;
    logic startPulse;
    logic needBus;
  } ctlStrobe_t;

  localparam int STROBE_W = $bits(ctlStrobe_t);

endpackage

// File: rtl/mst_bus_own_ctl.sv
module mst_bus_own_ctl
  import mst_bus_own_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       xferReq,
  input  logic       xferDone,
  input  logic       grantIn,
  output ctlStrobe_t strobes
);

  arbState_t curState;
  arbState_t nextState;
  logic      startNow;

  always_comb begin
    nextState = curState;
    startNow  = 1'b0;
    unique case (curState)
      ST_RESET: begin
        nextState = ST_INACTIVE;
      end
      ST_INACTIVE: begin
        if (grantIn && xferReq) begin
          nextState = ST_OWNER;
          startNow  = 1'b1;
        end else if (grantIn) begin
          nextState = ST_PARKED;
        end
      end
      ST_PARKED: begin
        if (!grantIn) begin
          nextState = ST_INACTIVE;
        end else if (xferReq) begin
          nextState = ST_OWNER;
          startNow  = 1'b1;
        end
      end
      ST_OWNER: begin
        if (xferDone) begin
          if (!grantIn) begin
            nextState = ST_INACTIVE;
          end else if (xferReq) begin
            nextState = ST_OWNER;
            startNow  = 1'b1;
          end else begin
            nextState = ST_PARKED;
          end
        end
      end
      default: nextState = ST_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= ST_RESET;
    else       curState <= nextState;
  end

  always_comb begin
    strobes.drvBus     = (nextState == ST_OWNER) || (nextState == ST_PARKED);
    strobes.drvBd      = (nextState == ST_OWNER);
    strobes.startPulse = startNow;
    strobes.needBus    = (nextState == ST_INACTIVE) && xferReq && (curState != ST_RESET);
  end

endmodule

// File: rtl/mst_bus_own_dp.sv
module mst_bus_own_dp
  import mst_bus_own_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t strobes,
  output logic       busReqOut,
  output logic       busDrivenOut,
  output logic       busOe,
  output logic       xferStart
);

  ctlStrobe_t outReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outReg <= '0;
    else       outReg <= strobes;
  end

  assign busReqOut    = outReg.needBus;
  assign busDrivenOut = outReg.drvBd;
  assign busOe        = outReg.drvBus;
  assign xferStart    = outReg.startPulse;

endmodule

// File: rtl/mst_bus_own.sv
module mst_bus_own
  import mst_bus_own_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic xferReq,
  input  logic xferDone,
  input  logic grantIn,
  output logic busReqOut,
  output logic busDrivenOut,
  output logic busOe,
  output logic xferStart
);

  ctlStrobe_t strobes;

  mst_bus_own_ctl ctl_i (
    .clk      (clk),
    .rstN     (rstN),
    .xferReq  (xferReq),
    .xferDone (xferDone),
    .grantIn  (grantIn),
    .strobes  (strobes)
  );

  mst_bus_own_dp dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .busReqOut    (busReqOut),
    .busDrivenOut (busDrivenOut),
    .busOe        (busOe),
    .xferStart    (xferStart)
  );

endmodule

// File: rtl/mst_bus_own_chk.sv
module mst_bus_own_chk (
  input logic clk,
  input logic rstN,
  input logic xferReq,
  input logic xferDone,
  input logic grantIn,
  input logic busReqOut,
  input logic busDrivenOut,
  input logic busOe,
  input logic xferStart
);

  logic armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    !armed |-> (!busReqOut && !busDrivenOut && !busOe && !xferStart));

  a_r2_request_follows_need: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !busOe && !grantIn && xferReq) |=> busReqOut);

  a_r3_start_marks_owner: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |-> (busDrivenOut && busOe && !busReqOut));

  a_r3_start_needs_grant: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !busDrivenOut && grantIn && xferReq) |=> (xferStart && busDrivenOut));

  a_r4_park_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !busDrivenOut && grantIn && !xferReq) |=> (busOe && !busDrivenOut));

  a_r6_hold_until_done: assert property (@(posedge clk) disable iff (!rstN)
    (busDrivenOut && !xferDone) |=> (busDrivenOut && busOe));

  a_r7_release_together: assert property (@(posedge clk) disable iff (!rstN)
    (busDrivenOut && xferDone && !grantIn) |=> (!busDrivenOut && !busOe));

  a_r8_keep_bus_granted: assert property (@(posedge clk) disable iff (!rstN)
    (busDrivenOut && xferDone && grantIn) |=> busOe);

  a_r9_drop_without_grant: assert property (@(posedge clk) disable iff (!rstN)
    (!busDrivenOut && !grantIn) |=> (!busOe && !xferStart));

  a_r10_request_ignored_midway: assert property (@(posedge clk) disable iff (!rstN)
    (busDrivenOut && !xferDone) |=> (!xferStart && !busReqOut));

  a_r11_bd_needs_oe: assert property (@(posedge clk) disable iff (!rstN)
    busDrivenOut |-> busOe);

  a_r11_req_not_owner: assert property (@(posedge clk) disable iff (!rstN)
    busReqOut |-> !busOe);

endmodule

bind mst_bus_own mst_bus_own_chk chk_i (.*);

// File: tb/mst_bus_own_tb_top.sv
`timescale 1ns/1ps
module mst_bus_own_tb_top;

  localparam int RAND_CYCLES = 3000;
  localparam int WATCHDOG_CYCLES = 200000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic xferReq = 1'b0;
  logic xferDone = 1'b0;
  logic grantIn = 1'b0;
  logic busReqOut, busDrivenOut, busOe, xferStart;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // model: 0 reset, 1 inactive, 2 parked, 3 owner
  int mState = 0;
  bit eBr = 0, eBd = 0, eOe = 0, eSt = 0;
  string curTag = "R1";

  always #2 clk = ~clk;

  mst_bus_own dut_i (
    .clk          (clk),
    .rstN         (rstN),
    .xferReq      (xferReq),
    .xferDone     (xferDone),
    .grantIn      (grantIn),
    .busReqOut    (busReqOut),
    .busDrivenOut (busDrivenOut),
    .busOe        (busOe),
    .xferStart    (xferStart)
  );

  function automatic string pickTag(int s, bit r, bit g, bit d);
    case (s)
      0: return "R1";
      1: return (g && r) ? "R3" : (g ? "R4" : "R2");
      2: return !g ? "R9" : (r ? "R5" : "R4");
      default: return !d ? (r ? "R10" : "R6") : (g ? "R8" : "R7");
    endcase
  endfunction

  function automatic int nextModelState(int s, bit r, bit g, bit d);
    case (s)
      0: return 1;
      1: return (g && r) ? 3 : (g ? 2 : 1);
      2: return !g ? 1 : (r ? 3 : 2);
      default: return !d ? 3 : (!g ? 1 : (r ? 3 : 2));
    endcase
  endfunction

  function automatic bit startExpected(int s, bit r, bit g, bit d);
    case (s)
      1: return g && r;
      2: return g && r;
      3: return d && g && r;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check1(string tag, string what, bit act, bit exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic checkAll();
    check1(curTag, "busReqOut", busReqOut, eBr);
    check1(curTag, "busDrivenOut", busDrivenOut, eBd);
    check1(curTag, "busOe", busOe, eOe);
    check1(curTag, "xferStart", xferStart, eSt);
    total++;
    if ((busDrivenOut && !busOe) || (busReqOut && busOe)) begin
      bad++;
      $display("FAIL R11 invariant actual=%0b%0b%0b expected=consistent",
               busReqOut, busDrivenOut, busOe);
    end
  endtask

  // drive inputs away from the edge, advance one edge, update model, check
  task automatic step(bit r, bit g, bit d);
    int ns;
    xferReq  = r;
    xferDone = d;
    grantIn  = g;
    @(posedge clk);
    curTag = pickTag(mState, r, g, d);
    ns  = nextModelState(mState, r, g, d);
    eSt = startExpected(mState, r, g, d);
    eBd = (ns == 3);
    eOe = (ns == 3) || (ns == 2);
    eBr = (ns == 1) && r && (mState != 0);
    mState = ns;
    @(negedge clk);
    checkAll();
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    finish();
  end

  initial begin
    bit r, g, d;
    void'($urandom(32'h5EED_0042));
    // R1: outputs quiet during reset
    repeat (3) @(negedge clk);
    curTag = "R1";
    checkAll();
    rstN = 1'b1;
    // R1: first edge out of reset, request and grant ignored
    step(1, 1, 0);
    // R2: request without grant
    step(1, 0, 0);
    step(1, 0, 0);
    // R3: grant with pending request
    step(1, 1, 0);
    // R6: grant withdrawn mid-access, request dropped after start
    step(0, 0, 0);
    // R10: new request during access ignored
    step(1, 0, 0);
    // R7: completion with grant low releases bus
    step(0, 0, 1);
    // R4: grant with no request parks
    step(0, 1, 0);
    // R5: request while parked
    step(1, 1, 0);
    // R8: done with grant, no request -> parked
    step(0, 1, 1);
    step(1, 1, 0);
    step(0, 1, 0);
    // R8: done with grant and request -> back-to-back start
    step(1, 1, 1);
    step(0, 0, 0);
    // R7: done without grant, request pending -> BR
    step(1, 0, 1);
    step(0, 1, 0);
    // R9: grant withdrawn while parked
    step(0, 0, 0);

    r = 0; g = 0;
    for (int i = 0; i < RAND_CYCLES; i++) begin
      if (($urandom % 4) == 0) g = ~g;
      if (eSt) r = 0;
      else if (!r) r = (($urandom % 3) == 0);
      d = eBd && (($urandom % 3) == 0);
      step(r, g, d);
    end
    finish();
  end

endmodule